// File: doc/BRIEF.md
# Per-Port Source Address Intrusion Guard

This block watches the source address of every frame received on each port of a repeater. When a frame's source address is captured, it is compared against a preferred reference address configured for that port. Any difference raises a sticky per-port interrupt that the host clears with an acknowledge strobe.

Each port can also lock itself out against intruders. The set of trusted addresses for a port holds up to two entries: the configured preferred address and the source address of the last good frame. Each entry has its own enable. With automatic locking on, a frame whose source matches no enabled entry locks the port. The lock happens only when that frame ends good. Once locked, the port stays locked until a management unlock strobe releases it. The number of ports is a parameter, and all ports work independently.

Top module: `sa_guard`

## Requirements
- R1: After reset every port is unlocked, every interrupt is clear, and every last-seen address is zero.
- R2: When a port's source-address strobe is high and the address differs from that port's preferred address, the port's interrupt is high from the next cycle. This happens whatever the compare-enable and auto-lock settings are.
- R3: A port's interrupt stays high until a cycle in which its acknowledge strobe is high, and clears after that cycle. If a new mismatch arrives in the same cycle as the acknowledge, the interrupt stays high.
- R4: With auto-lock on, a frame ending good whose captured address matches no enabled trusted entry sets the port's lock output from the cycle after the end strobe.
- R5: A captured address equal to an enabled trusted entry never locks the port. Equality with an entry whose enable is clear gives no protection.
- R6: With both compare enables clear, no frame ever locks the port.
- R7: A frame whose end strobe comes with the good flag low neither locks the port nor changes its last-seen address. A frame that ends without a captured address since its start has the same effect.
- R8: On a good frame end, the last-seen address takes that frame's captured address from the next cycle. The trusted-entry compare for that frame uses the previous last-seen value.
- R9: A lock persists across later frames until a management unlock strobe, and clears after that cycle. If a locking frame end falls in the same cycle as an unlock strobe, the port is locked.
- R10: With auto-lock off, no frame locks the port, intruder or not.
- R11: The combined interrupt output is high exactly when at least one port's interrupt is high.
- R12: Activity on one port never changes another port's lock, interrupt or last-seen address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_start | input | NPORTS | Frame start strobe per port |
| rx_sa_stb | input | NPORTS | Source address valid strobe per port |
| rx_sa | input | NPORTS*48 | Source address per port, port p in bits [p*48 +: 48] |
| rx_end | input | NPORTS | End of frame strobe per port, after the checksum |
| rx_good | input | NPORTS | Frame valid flag, sampled with rx_end |
| cfg_pref_addr | input | NPORTS*48 | Preferred reference address per port |
| cfg_pref_en | input | NPORTS | Preferred address trusted-entry enable |
| cfg_last_en | input | NPORTS | Last-seen address trusted-entry enable |
| cfg_auto_lock | input | NPORTS | Automatic intruder lock enable |
| mgmt_unlock | input | NPORTS | Management strobe that releases a lock |
| irq_ack | input | NPORTS | Host strobe that clears the interrupt |
| port_locked | output | NPORTS | Port disabled by intruder lock |
| sa_irq | output | NPORTS | Sticky mismatch interrupt per port |
| sa_irq_any | output | 1 | OR of all port interrupts |
| last_sa | output | NPORTS*48 | Last good frame source address per port |

## Verification
The hardest case to reach is the ordering around the last-seen entry. A frame must be judged against the address of the previous good frame while its own address is being stored. The bench builds chains of frames in which the preferred entry is disabled or deliberately wrong, so that only the old last-seen value decides the outcome. It also drives the collision cycles on purpose: an acknowledge together with a fresh mismatch, and an unlock together with a locking end. This confirms that the event which sets a flag beats the strobe that clears it.

// File: rtl/sag_pkg.sv
package sag_pkg;
  localparam int SAG_AW = 48;

  typedef logic [SAG_AW-1:0] mac_t;

  typedef struct packed {
    logic pref_en;
    logic last_en;
    logic auto_en;
  } guard_cfg_t;

  // true when the entry is enabled and equals the address
  function automatic logic entry_hit(mac_t addr, mac_t entry, logic en);
    return en && (addr == entry);
  endfunction

  // an intruder exists only when at least one entry is trusted and none hit
  function automatic logic is_intruder(mac_t addr, mac_t pref, mac_t last,
                                       logic pref_en, logic last_en);
    logic any_trusted;
    logic any_hit;
    any_trusted = pref_en | last_en;
    any_hit     = entry_hit(addr, pref, pref_en) | entry_hit(addr, last, last_en);
    return any_trusted && !any_hit;
  endfunction
endpackage

// File: rtl/sag_cmp.sv
module sag_cmp
  import sag_pkg::*;
(
  input  mac_t sa,
  input  mac_t pref,
  input  mac_t last,
  input  logic pref_en,
  input  logic last_en,
  output logic pref_miss,
  output logic intrude
);
  always_comb begin
    pref_miss = (sa != pref);
    intrude   = is_intruder(sa, pref, last, pref_en, last_en);
  end
endmodule

// File: rtl/sag_irq.sv
module sag_irq (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (set_ev) flag <= 1'b1;
    else if (clr_ev) flag <= 1'b0;
  end
endmodule

// File: rtl/sag_port.sv
module sag_port
  import sag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       sa_stb,
  input  mac_t       sa,
  input  logic       fend,
  input  logic       fok,
  input  mac_t       pref,
  input  guard_cfg_t cfg,
  input  logic       unlock,
  output logic       locked,
  output mac_t       last,
  output logic       ev_miss,
  output logic       ev_good_end,
  output logic       ev_lock
);
  mac_t sa_q;
  mac_t last_q;
  logic seen_q;
  logic intr_q;
  logic lock_q;
  logic pref_miss;
  logic intrude;

  sag_cmp u_cmp (
    .sa       (sa),
    .pref     (pref),
    .last     (last_q),
    .pref_en  (cfg.pref_en),
    .last_en  (cfg.last_en),
    .pref_miss(pref_miss),
    .intrude  (intrude)
  );

  assign ev_miss     = sa_stb & pref_miss;
  assign ev_good_end = fend & fok & seen_q;
  assign ev_lock     = ev_good_end & cfg.auto_en & intr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa_q   <= '0;
      seen_q <= 1'b0;
      intr_q <= 1'b0;
    end else begin
      if (start || fend) begin
        seen_q <= 1'b0;
        intr_q <= 1'b0;
      end
      if (sa_stb) begin
        sa_q   <= sa;
        seen_q <= 1'b1;
        intr_q <= intrude;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              last_q <= '0;
    else if (ev_good_end) last_q <= sa_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          lock_q <= 1'b0;
    else if (ev_lock) lock_q <= 1'b1;
    else if (unlock)  lock_q <= 1'b0;
  end

  assign locked = lock_q;
  assign last   = last_q;
endmodule

// File: rtl/sa_guard.sv
module sa_guard
  import sag_pkg::*;
#(
  parameter int NPORTS = 4,
  localparam int AW = SAG_AW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORTS-1:0]  rx_start,
  input  logic [NPORTS-1:0]  rx_sa_stb,
  input  logic [NPORTS*AW-1:0] rx_sa,
  input  logic [NPORTS-1:0]  rx_end,
  input  logic [NPORTS-1:0]  rx_good,
  input  logic [NPORTS*AW-1:0] cfg_pref_addr,
  input  logic [NPORTS-1:0]  cfg_pref_en,
  input  logic [NPORTS-1:0]  cfg_last_en,
  input  logic [NPORTS-1:0]  cfg_auto_lock,
  input  logic [NPORTS-1:0]  mgmt_unlock,
  input  logic [NPORTS-1:0]  irq_ack,
  output logic [NPORTS-1:0]  port_locked,
  output logic [NPORTS-1:0]  sa_irq,
  output logic               sa_irq_any,
  output logic [NPORTS*AW-1:0] last_sa
);
  logic [NPORTS-1:0] ev_miss;
  logic [NPORTS-1:0] ev_good_end;
  logic [NPORTS-1:0] ev_lock;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    guard_cfg_t cfg_p;
    mac_t       last_p;

    assign cfg_p = '{pref_en: cfg_pref_en[p],
                     last_en: cfg_last_en[p],
                     auto_en: cfg_auto_lock[p]};

    sag_port u_port (
      .clk        (clk),
      .rst        (rst),
      .start      (rx_start[p]),
      .sa_stb     (rx_sa_stb[p]),
      .sa         (rx_sa[p*AW +: AW]),
      .fend       (rx_end[p]),
      .fok        (rx_good[p]),
      .pref       (cfg_pref_addr[p*AW +: AW]),
      .cfg        (cfg_p),
      .unlock     (mgmt_unlock[p]),
      .locked     (port_locked[p]),
      .last       (last_p),
      .ev_miss    (ev_miss[p]),
      .ev_good_end(ev_good_end[p]),
      .ev_lock    (ev_lock[p])
    );

    assign last_sa[p*AW +: AW] = last_p;

    sag_irq u_irq (
      .clk   (clk),
      .rst   (rst),
      .set_ev(ev_miss[p]),
      .clr_ev(irq_ack[p]),
      .flag  (sa_irq[p])
    );
  end

  assign sa_irq_any = |sa_irq;
endmodule

// File: rtl/sa_guard_chk.sv
module sa_guard_chk #(
  parameter int NPORTS = 4,
  parameter int AW = 48
) (
  input logic               clk,
  input logic               rst,
  input logic [NPORTS-1:0]  rx_sa_stb,
  input logic [NPORTS*AW-1:0] rx_sa,
  input logic [NPORTS-1:0]  rx_end,
  input logic [NPORTS-1:0]  rx_good,
  input logic [NPORTS*AW-1:0] cfg_pref_addr,
  input logic [NPORTS-1:0]  cfg_pref_en,
  input logic [NPORTS-1:0]  cfg_last_en,
  input logic [NPORTS-1:0]  cfg_auto_lock,
  input logic [NPORTS-1:0]  mgmt_unlock,
  input logic [NPORTS-1:0]  irq_ack,
  input logic [NPORTS-1:0]  port_locked,
  input logic [NPORTS-1:0]  sa_irq,
  input logic               sa_irq_any,
  input logic [NPORTS*AW-1:0] last_sa,
  input logic [NPORTS-1:0]  ev_good_end
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    // R2
    miss_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_sa_stb[p] && rx_sa[p*AW +: AW] != cfg_pref_addr[p*AW +: AW]) |=> sa_irq[p]);
    // R3
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (sa_irq[p] && !irq_ack[p]) |=> sa_irq[p]);
    // R9
    lock_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (port_locked[p] && !mgmt_unlock[p]) |=> port_locked[p]);
    // R6
    no_entry_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (!port_locked[p] && !cfg_pref_en[p] && !cfg_last_en[p]) |=> !port_locked[p]);
    // R10
    auto_off_no_lock_chk: assert property (@(posedge clk) disable iff (rst)
      (!port_locked[p] && !cfg_auto_lock[p]) |=> !port_locked[p]);
    // R7
    bad_end_keeps_last_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_end[p] && !rx_good[p]) |=> $stable(last_sa[p*AW +: AW]));
    // R4
    lock_after_good_end_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(port_locked[p]) |-> $past(ev_good_end[p]));
  end

  // R11
  irq_any_chk: assert property (@(posedge clk) disable iff (rst)
    sa_irq_any == (sa_irq != '0));
endmodule

bind sa_guard sa_guard_chk #(.NPORTS(NPORTS), .AW(AW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .rx_sa_stb    (rx_sa_stb),
  .rx_sa        (rx_sa),
  .rx_end       (rx_end),
  .rx_good      (rx_good),
  .cfg_pref_addr(cfg_pref_addr),
  .cfg_pref_en  (cfg_pref_en),
  .cfg_last_en  (cfg_last_en),
  .cfg_auto_lock(cfg_auto_lock),
  .mgmt_unlock  (mgmt_unlock),
  .irq_ack      (irq_ack),
  .port_locked  (port_locked),
  .sa_irq       (sa_irq),
  .sa_irq_any   (sa_irq_any),
  .last_sa      (last_sa),
  .ev_good_end  (ev_good_end)
);

// File: tb/test_sa_guard.sv
module test_sa_guard;
  localparam int NP = 4;
  localparam int AW = 48;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [NP-1:0] rx_start = '0, rx_sa_stb = '0, rx_end = '0, rx_good = '0;
  logic [NP-1:0] pref_en = '0, last_en = '0, auto_lock = '0, unlock = '0, ack = '0;
  logic [AW-1:0] sa_in [NP];
  logic [AW-1:0] pref_in [NP];
  logic [NP*AW-1:0] rx_sa_flat, pref_flat, last_flat;
  logic [NP-1:0] locked, irq;
  logic irq_any;

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rx_sa_flat[p*AW +: AW] = sa_in[p];
      pref_flat[p*AW +: AW]  = pref_in[p];
    end
  end

  sa_guard #(.NPORTS(NP)) i_sa_guard (
    .clk(clk), .rst(rst), .rx_start(rx_start), .rx_sa_stb(rx_sa_stb),
    .rx_sa(rx_sa_flat), .rx_end(rx_end), .rx_good(rx_good),
    .cfg_pref_addr(pref_flat), .cfg_pref_en(pref_en), .cfg_last_en(last_en),
    .cfg_auto_lock(auto_lock), .mgmt_unlock(unlock), .irq_ack(ack),
    .port_locked(locked), .sa_irq(irq), .sa_irq_any(irq_any), .last_sa(last_flat)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference
  bit            m_lock [NP];
  bit            m_irq  [NP];
  logic [AW-1:0] m_last [NP];
  logic [AW-1:0] m_cap  [NP];
  bit            m_have [NP];
  bit            m_bad  [NP];

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (rst) begin
        m_lock[p] = 0; m_irq[p] = 0; m_last[p] = '0;
        m_cap[p] = '0; m_have[p] = 0; m_bad[p] = 0;
      end else begin
        bit trusted;
        bit good_end;
        trusted = 0;
        good_end = rx_end[p] && rx_good[p] && m_have[p];
        if (good_end) begin
          if (auto_lock[p] && m_bad[p]) m_lock[p] = 1;
          else if (unlock[p]) m_lock[p] = 0;
          m_last[p] = m_cap[p];
        end else if (unlock[p]) m_lock[p] = 0;
        if (rx_sa_stb[p] && sa_in[p] != pref_in[p]) m_irq[p] = 1;
        else if (ack[p]) m_irq[p] = 0;
        if (rx_start[p] || rx_end[p]) begin m_have[p] = 0; m_bad[p] = 0; end
        if (rx_sa_stb[p]) begin
          if (pref_en[p] && sa_in[p] == pref_in[p]) trusted = 1;
          if (last_en[p] && sa_in[p] == (good_end ? m_cap[p] : m_last[p])) trusted = 1;
          m_cap[p] = sa_in[p];
          m_have[p] = 1;
          m_bad[p] = (pref_en[p] || last_en[p]) && !trusted;
        end
      end
    end
  end

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit any;
      any = 0;
      for (int p = 0; p < NP; p++) begin
        check("R4 lock vs model", {47'd0, locked[p]}, {47'd0, m_lock[p]});
        check("R2 irq vs model", {47'd0, irq[p]}, {47'd0, m_irq[p]});
        check("R8 last vs model", last_flat[p*AW +: AW], m_last[p]);
        any |= m_irq[p];
      end
      check("R11 irq_any vs model", {47'd0, irq_any}, {47'd0, any});
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  // one frame on port p; optional ack with the address strobe, unlock with the end
  task automatic frame(int p, logic [AW-1:0] a, bit ok, bit ack_sa = 0, bit unl_end = 0);
    rx_start[p] = 1; tick(); rx_start[p] = 0;
    sa_in[p] = a; rx_sa_stb[p] = 1; ack[p] = ack_sa; tick();
    rx_sa_stb[p] = 0; ack[p] = 0; tick();
    rx_end[p] = 1; rx_good[p] = ok; unlock[p] = unl_end; tick();
    rx_end[p] = 0; rx_good[p] = 0; unlock[p] = 0; tick();
  endtask

  task automatic pulse_ack(int p);
    ack[p] = 1; tick(); ack[p] = 0; tick();
  endtask

  task automatic pulse_unlock(int p);
    unlock[p] = 1; tick(); unlock[p] = 0; tick();
  endtask

  localparam logic [AW-1:0] A = 48'h0A0B0C0D0E0F;
  localparam logic [AW-1:0] B = 48'h112233445566;
  localparam logic [AW-1:0] C = 48'hC0FFEE000001;
  localparam logic [AW-1:0] D = 48'hDEAD00BEEF02;
  localparam logic [AW-1:0] E = 48'h00000000E0E0;

  initial begin
    for (int p = 0; p < NP; p++) begin sa_in[p] = '0; pref_in[p] = A; end
    repeat (3) tick();
    rst = 0; tick();
    // R1 reset state
    check("R1 locked", {44'd0, locked}, '0);
    check("R1 irq", {44'd0, irq}, '0);
    check("R1 last", last_flat[AW-1:0], '0);

    pref_en[0] = 1; auto_lock[0] = 1;
    frame(0, A, 1);                           // R5 trusted preferred
    check("R5 match keeps unlocked", {47'd0, locked[0]}, '0);
    check("R2 no mismatch no irq", {47'd0, irq[0]}, '0);
    frame(0, B, 1);                           // R4 intruder
    check("R4 intruder locks", {47'd0, locked[0]}, 48'd1);
    check("R2 mismatch irq", {47'd0, irq[0]}, 48'd1);
    check("R8 last takes B", last_flat[AW-1:0], B);
    frame(0, A, 1);                           // R9 later good frame
    check("R9 lock persists", {47'd0, locked[0]}, 48'd1);
    check("R3 irq sticky", {47'd0, irq[0]}, 48'd1);
    pulse_ack(0);
    check("R3 ack clears", {47'd0, irq[0]}, '0);
    pulse_unlock(0);
    check("R9 unlock clears", {47'd0, locked[0]}, '0);

    // R8 compare uses old last-seen value; last = A now
    last_en[0] = 1; pref_in[0] = C;
    frame(0, A, 1);
    check("R5 last entry trusted", {47'd0, locked[0]}, '0);
    check("R2 irq without enables mattering", {47'd0, irq[0]}, 48'd1);
    frame(0, D, 1);
    check("R8 old last used, lock", {47'd0, locked[0]}, 48'd1);
    check("R8 last takes D", last_flat[AW-1:0], D);
    pulse_unlock(0);

    // R5 disabled preferred entry gives no protection
    pref_en[0] = 0;
    frame(0, C, 1);
    check("R5 disabled entry no help", {47'd0, locked[0]}, 48'd1);
    pulse_unlock(0);

    // R6 no trusted entries
    last_en[0] = 0;
    frame(0, E, 1);
    check("R6 no entries no lock", {47'd0, locked[0]}, '0);

    // R7 bad end
    pref_en[0] = 1;
    frame(0, B, 0);
    check("R7 bad end no lock", {47'd0, locked[0]}, '0);
    check("R7 bad end keeps last", last_flat[AW-1:0], E);
    rx_end[0] = 1; rx_good[0] = 1; tick(); rx_end[0] = 0; rx_good[0] = 0; tick();
    check("R7 end without address keeps last", last_flat[AW-1:0], E);

    // R10 auto off
    auto_lock[0] = 0;
    frame(0, B, 1);
    check("R10 auto off no lock", {47'd0, locked[0]}, '0);
    auto_lock[0] = 1;

    // R3 ack collides with new mismatch; R9 unlock collides with locking end
    pulse_ack(0);
    frame(0, D, 1, 1, 1);
    check("R3 set beats ack", {47'd0, irq[0]}, 48'd1);
    check("R9 lock beats unlock", {47'd0, locked[0]}, 48'd1);
    pulse_ack(0);

    // R12 / R11 other ports independent
    pref_en[2] = 1; auto_lock[2] = 1;
    frame(2, B, 1);
    check("R12 port2 locks", {47'd0, locked[2]}, 48'd1);
    check("R12 port0 irq untouched", {47'd0, irq[0]}, '0);
    check("R12 port0 last untouched", last_flat[AW-1:0], D);
    check("R11 irq_any", {47'd0, irq_any}, 48'd1);
    pulse_ack(2);
    check("R11 irq_any low", {47'd0, irq_any}, '0);

    repeat (3) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule